// File: doc/BRIEF.md
# Two-Rank Input Register for a 12-bit Converter

This block is the digital front end of a 12-bit current-output converter. Data enters through a first rank, the staging register, built from an 8-bit upper section and a 4-bit lower section. A host writes it from a parallel bus under an active-low select, an active-low load strobe and a width control. The width control decides whether the whole word is taken or only the lower nibble. Because of this, a narrow bus can present the upper eight bits first and the low nibble second.

A second rank, the code register, drives the converter core. It copies the staging register while an active-low arm signal and an active-low commit signal are both low. Several converters can each be staged in their own time and then switch together with one shared commit. Every control acts on its level. The transparent-latch behaviour is modelled by registers that load on each clock edge where their enable holds, so the block stays fully synchronous.

Top module: `dual_rank_dac_reg`

## Requirements
- R1: A synchronous active-high reset clears both the staging register and the code register to zero. Reset takes priority over every control input.
- R2: At a clock edge where `sel_n`=0, `load_n`=0 and `wide`=1, all 12 bits of the staging register take `din` (bit 0 is the LSB, bit 11 the MSB).
- R3: At a clock edge where `sel_n`=0, `load_n`=0 and `wide`=0, only staging bits 3:0 take `din[3:0]`. Bits 11:4 keep their value.
- R4: While `sel_n` or `load_n` is high, the staging register keeps its value whatever `din` and `wide` carry.
- R5: At a clock edge where `arm_n`=0 and `commit_n`=0, the code register takes the staging value. The new code is visible after that edge.
- R6: While `arm_n` or `commit_n` is high, the code register keeps its value.
- R7: `sel_n` has no effect on the transfer: a commit with `sel_n`=1 still updates the code register.
- R8: When a staging load and a commit happen at the same edge, the code register takes the staging value from before that edge. The new data reaches the code one commit later.
- R9: A commit with no write in between copies the unchanged staging value again, so a repeated commit leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Device select, active low; qualifies `load_n` |
| load_n | input | 1 | Staging load strobe, active low |
| wide | input | 1 | 1: load all 12 bits; 0: load bits 3:0 only |
| arm_n | input | 1 | Transfer qualifier, active low |
| commit_n | input | 1 | Transfer strobe, active low |
| din | input | 12 | Parallel data, bit 11 is the MSB |
| stage_o | output | 12 | Current staging register contents |
| code_o | output | 12 | Code register driving the converter core |

## Verification
Every result is due at the first clock edge after the controls that cause it. A staging load shows on `stage_o`, and a commit on `code_o`, one edge after the inputs are applied. A commit at the same edge as a load shows the old staging value. The bench drives the inputs on the falling edge and advances a reference model of both ranks once for each rising edge. It compares both outputs at the next falling edge, so each check sits exactly one register stage after its stimulus. All 32 combinations of the five controls are swept over many data words. Directed sequences then cover the split-byte write, a repeated commit and reset priority.

// File: rtl/dual_rank_dac_pkg.sv
package dual_rank_dac_pkg;

  // Decoded, active-high write enables for the two ranks.
  typedef struct packed {
    logic load_hi;   // upper section of staging register
    logic load_lo;   // lower section of staging register
    logic move;      // staging -> code transfer
  } rank_en_t;

endpackage

// File: rtl/dual_rank_dac_decode.sv
module dual_rank_dac_decode
  import dual_rank_dac_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sel_n,
  input  logic     load_n,
  input  logic     wide,
  input  logic     arm_n,
  input  logic     commit_n,
  output rank_en_t en
);

  logic write_ok;

  always_comb begin
    write_ok   = ~sel_n & ~load_n;
    en.load_lo = write_ok;
    en.load_hi = write_ok & wide;
    en.move    = ~arm_n & ~commit_n;  // select deliberately not involved
  end

  // The upper section never loads without the lower one.
  assert_hi_needs_lo_R3: assert property (@(posedge clk) disable iff (rst)
    en.load_hi |-> en.load_lo);

  // Transfer enable follows arm/commit, independent of select.
  assert_move_ignores_sel_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_n && !arm_n && !commit_n) |-> en.move);

endmodule

// File: rtl/dual_rank_dac_section.sv
module dual_rank_dac_section #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  assert_section_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));

  assert_section_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

endmodule

// File: rtl/dual_rank_dac_code.sv
module dual_rank_dac_code #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         move,
  input  logic [W-1:0] stage_q,
  output logic [W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (rst)       code_q <= '0;
    else if (move) code_q <= stage_q;
  end

  // Takes the staging value present before the edge (R5, R8).
  assert_code_takes_stage_R5: assert property (@(posedge clk) disable iff (rst)
    move |=> code_q == $past(stage_q));

  assert_code_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !move |=> $stable(code_q));

endmodule

// File: rtl/dual_rank_dac_reg.sv
module dual_rank_dac_reg
  import dual_rank_dac_pkg::*;
#(
  parameter int HI_W = 8,
  parameter int LO_W = 4,
  parameter int CODE_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              load_n,
  input  logic              wide,
  input  logic              arm_n,
  input  logic              commit_n,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] stage_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int NSEC = 2;

  rank_en_t en;

  dual_rank_dac_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_n),
    .load_n   (load_n),
    .wide     (wide),
    .arm_n    (arm_n),
    .commit_n (commit_n),
    .en       (en)
  );

  // Section 0: low nibble, section 1: upper byte.
  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    localparam int SW  = (s == 0) ? LO_W : HI_W;
    localparam int LSB = (s == 0) ? 0 : LO_W;
    dual_rank_dac_section #(.W(SW)) u_sec (
      .clk  (clk),
      .rst  (rst),
      .load ((s == 0) ? en.load_lo : en.load_hi),
      .d    (din[LSB +: SW]),
      .q    (stage_o[LSB +: SW])
    );
  end

  dual_rank_dac_code #(.W(CODE_W)) u_code (
    .clk     (clk),
    .rst     (rst),
    .move    (en.move),
    .stage_q (stage_o),
    .code_q  (code_o)
  );

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (stage_o == '0 && code_o == '0));

  assert_narrow_keeps_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !load_n && !wide) |=> $stable(stage_o[CODE_W-1:LO_W]));

  assert_commit_without_sel_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_n && !arm_n && !commit_n) |=> code_o == $past(stage_o));

endmodule

// File: tb/dual_rank_dac_reg_test.sv
`timescale 1ns/1ps
module dual_rank_dac_reg_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1, load_n = 1'b1, wide = 1'b0;
  logic        arm_n = 1'b1, commit_n = 1'b1;
  logic [11:0] din = '0;
  logic [11:0] stage_o, code_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [11:0] m_stage = '0, m_code = '0;

  always #2 clk = ~clk;  // 250 MHz

  dual_rank_dac_reg uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .load_n(load_n), .wide(wide),
    .arm_n(arm_n), .commit_n(commit_n), .din(din),
    .stage_o(stage_o), .code_o(code_o)
  );

  task automatic check(string req, string what, logic [11:0] act, logic [11:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %03h expected %03h", req, what, act, exp);
    end
  endtask

  // Drive at falling edge, model the rising edge, check at next falling edge.
  task automatic step(logic s, logic l, logic w, logic a, logic c, logic [11:0] d);
    logic en, go;
    string rs, rc;
    sel_n = s; load_n = l; wide = w; arm_n = a; commit_n = c; din = d;
    en = !s && !l;
    go = !a && !c;
    rs = !en ? "R4" : (w ? "R2" : "R3");
    rc = !go ? "R6" : (en ? "R8" : (s ? "R7" : "R5"));
    if (go) m_code = m_stage;
    if (en) begin
      m_stage[3:0] = d[3:0];
      if (w) m_stage[11:4] = d[11:4];
    end
    @(negedge clk);
    check(rs, "stage", stage_o, m_stage);
    check(rc, "code", code_o, m_code);
  endtask

  initial begin
    // R1: reset wins over active controls
    @(negedge clk);
    sel_n = 0; load_n = 0; wide = 1; arm_n = 0; commit_n = 0; din = 12'hFFF;
    repeat (3) @(negedge clk);
    check("R1", "stage", stage_o, 12'h000);
    check("R1", "code", code_o, 12'h000);
    rst = 0;
    sel_n = 1; load_n = 1; arm_n = 1; commit_n = 1;
    @(negedge clk);

    // Sweep all control combinations over many data words (R2..R8)
    for (int i = 0; i < 40; i++) begin
      for (int c = 0; c < 32; c++) begin
        step(c[0], c[1], c[2], c[3], c[4], 12'((i * 2731 + c * 157) ^ (i << 5)));
      end
    end

    // Split write: upper byte wide, then low nibble narrow, then commit (R3, R5)
    step(0, 0, 1, 1, 1, 12'hA5C);
    step(0, 0, 0, 1, 1, 12'h3F7);
    check("R3", "split stage", stage_o, 12'hA57);
    step(1, 1, 0, 0, 0, 12'h000);
    check("R5", "split code", code_o, 12'hA57);
    // R9: repeated commit without writes keeps code
    step(1, 1, 1, 0, 0, 12'hFFF);
    check("R9", "recommit code", code_o, 12'hA57);
    step(0, 1, 1, 0, 1, 12'h111);
    check("R9", "code after idle", code_o, 12'hA57);
    // R8: load and commit together; next commit brings new data
    step(0, 0, 1, 0, 0, 12'h0F0);
    check("R8", "old data moved", code_o, 12'hA57);
    step(1, 1, 1, 0, 0, 12'h000);
    check("R8", "new data moved", code_o, 12'h0F0);
    // R1 again mid-run
    rst = 1;
    @(negedge clk);
    check("R1", "stage after reset", stage_o, 12'h000);
    check("R1", "code after reset", code_o, 12'h000);
    rst = 0;

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule